// File: doc/BRIEF.md
# Saturating Wiper Position Controller

This block is the digital control section of a 32-step digitally controlled potentiometer. A host drives three slow, asynchronous control lines: an active-low select, an active-low increment strobe and a direction level. While the block is selected, each falling edge of the strobe moves a wiper position counter one step up or down. The counter stops at both ends and never wraps. The position is decoded into a one-hot tap-select vector, so that exactly one switch of the resistor array is closed at a time.

Ending a selection is what decides whether the current setting is saved. If the select line rises while the strobe is high, the position is committed to a nonvolatile shadow register. The commit is a timed write, and `store_busy` is high for the whole of it. If the select line rises while the strobe is low, nothing is saved. The position reached stays in effect until the next power cycle. On a power-on reset, the counter is reloaded from the nonvolatile register.

The nonvolatile cell is modelled as a register that keeps its value across `por_n`. A cell that has never been written holds `NV_INIT`. All three control lines pass through two-flop synchronizers, and the block acts on edges only after they have been synchronized.

Top module: `tapwiper_ctrl`

## Requirements
- R1: While `por_n` is low, the position is loaded from the nonvolatile register. A register that has never been written holds `NV_INIT`.
- R2: `tap_sel` has exactly one bit set, and that bit's index equals `position`.
- R3: During a selection, a falling edge on `inc_n` adds 1 to `position` when `dir_up` is 1 and subtracts 1 when it is 0. `position` changes on the third rising clock edge after the edge is first sampled.
- R4: A step up at position `TAPS-1` leaves the position at `TAPS-1`, and a step down at 0 leaves it at 0.
- R5: Falling edges on `inc_n` while `sel_n` is high leave `position` unchanged.
- R6: A rising edge on `sel_n` that ends a selection while `inc_n` is high raises `store_busy` for exactly `STORE_CYCLES` cycles. The position is written to the nonvolatile register at the end of that interval, and a later power cycle recalls it.
- R7: A rising edge on `sel_n` that ends a selection while `inc_n` is low does not raise `store_busy`. The position is kept, and a later power cycle recalls the previously stored value.
- R8: While `store_busy` is high, falling edges on `inc_n` are ignored, and so is a falling edge on `sel_n`. A selection begun during the store stays inactive until `sel_n` has gone high again.
- R9: `standby` is high exactly when no selection is active and no store is in progress. It is never high together with `store_busy`.
- R10: `dir_up` may change between steps within one selection, and each step follows the level of `dir_up` at its own strobe edge.
- R11: A power-on reset during a store cancels it: the nonvolatile register keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; triggers recall |
| sel_n | input | 1 | Select, active low, asynchronous |
| inc_n | input | 1 | Step strobe, acts on its falling edge, asynchronous |
| dir_up | input | 1 | Step direction, 1 = up, asynchronous |
| tap_sel | output | TAPS | One-hot tap switch enables |
| position | output | $clog2(TAPS) | Current wiper position |
| store_busy | output | 1 | Nonvolatile write in progress |
| standby | output | 1 | Idle: no selection and no store in progress |

## Verification
The bench builds the block with `TAPS=32`, `STORE_CYCLES=16` and `NV_INIT=5`. The short store interval lets the bench measure the busy window exactly. It also lets the bench drive strobes and new selections inside that window, and fire a reset in the middle of a write. Because the nonvolatile default is not zero, a recall from the blank cell can be told apart from a cleared counter. With 32 taps, both saturation ends can be reached within a few dozen strobe pulses.

// File: rtl/tw_pkg.sv
package tw_pkg;
  // Synchronized control lines, select in the top bit
  typedef struct packed {
    logic sel_n;
    logic inc_n;
    logic up;
  } tw_ctl_t;

  localparam tw_ctl_t CTL_IDLE = '{sel_n: 1'b1, inc_n: 1'b1, up: 1'b0};
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic meta_q, sync_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          meta_q <= RST_VAL[i];
          sync_q <= RST_VAL[i];
        end else begin
          meta_q <= d[i];
          sync_q <= meta_q;
        end
      end
      assign q[i] = sync_q;
    end
  endgenerate
endmodule

// File: rtl/tw_nvcell.sv
module tw_nvcell #(
  parameter int PW = 5,
  parameter logic [PW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_data,
  output logic [PW-1:0] rd_data
);
  // Not touched by reset: the blank-cell value comes from the initializer
  logic [PW-1:0] cell_q = INIT;

  always_ff @(posedge clk) begin
    if (wr_en) cell_q <= wr_data;
  end

  assign rd_data = cell_q;
endmodule

// File: rtl/tw_tapdec.sv
module tw_tapdec #(
  parameter int TAPS = 32,
  parameter int PW   = $clog2(TAPS)
) (
  input  logic [PW-1:0]   pos,
  output logic [TAPS-1:0] onehot
);
  generate
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
      assign onehot[i] = (pos == PW'(i));
    end
  endgenerate
endmodule

// File: rtl/tapwiper_ctrl.sv
module tapwiper_ctrl
  import tw_pkg::*;
#(
  parameter int TAPS         = 32,
  parameter int STORE_CYCLES = 1250000,
  parameter int NV_INIT      = 0
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    sel_n,
  input  logic                    inc_n,
  input  logic                    dir_up,
  output logic [TAPS-1:0]         tap_sel,
  output logic [$clog2(TAPS)-1:0] position,
  output logic                    store_busy,
  output logic                    standby
);
  localparam int PW = $clog2(TAPS);
  localparam int CW = $clog2(STORE_CYCLES + 1);
  localparam logic [PW-1:0] POS_TOP  = PW'(TAPS - 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(STORE_CYCLES - 1);

  tw_ctl_t     raw_ctl, syn_ctl, prev_q;
  logic [2:0]  syn_bits;
  logic [PW-1:0] pos_q, nv_data;
  logic [CW-1:0] cnt_q;
  logic        busy_q, sess_q;
  logic        sel_fall, sel_rise, inc_fall, step, nv_wr;

  assign raw_ctl = '{sel_n: sel_n, inc_n: inc_n, up: dir_up};

  tw_sync #(.W(3), .RST_VAL(CTL_IDLE)) u_sync (
    .clk(clk), .rst_n(por_n), .d(raw_ctl), .q(syn_bits)
  );
  assign syn_ctl = tw_ctl_t'(syn_bits);

  assign sel_fall = prev_q.sel_n & ~syn_ctl.sel_n;
  assign sel_rise = ~prev_q.sel_n & syn_ctl.sel_n;
  assign inc_fall = prev_q.inc_n & ~syn_ctl.inc_n;
  assign step     = sess_q & ~syn_ctl.sel_n & inc_fall;
  assign nv_wr    = por_n & busy_q & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      prev_q <= CTL_IDLE;
      pos_q  <= nv_data;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sess_q <= 1'b0;
    end else begin
      prev_q <= syn_ctl;
      if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
      if (step) begin
        if (syn_ctl.up) begin
          if (pos_q != POS_TOP) pos_q <= pos_q + 1'b1;
        end else begin
          if (pos_q != '0) pos_q <= pos_q - 1'b1;
        end
      end
      if (sess_q && sel_rise) begin
        sess_q <= 1'b0;
        if (syn_ctl.inc_n) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_LOAD;
        end
      end else if (!sess_q && sel_fall && !busy_q) begin
        sess_q <= 1'b1;
      end
    end
  end

  tw_nvcell #(.PW(PW), .INIT(PW'(NV_INIT))) u_nv (
    .clk(clk), .wr_en(nv_wr), .wr_data(pos_q), .rd_data(nv_data)
  );

  tw_tapdec #(.TAPS(TAPS), .PW(PW)) u_dec (
    .pos(pos_q), .onehot(tap_sel)
  );

  assign position   = pos_q;
  assign store_busy = busy_q;
  assign standby    = ~sess_q & ~busy_q;

  // R2
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($countones(tap_sel) == 1) && tap_sel[pos_q]);

  // R4
  no_wrap_top_chk: assert property (@(posedge clk) disable iff (!por_n)
    (pos_q == POS_TOP) |=> (pos_q != '0));

  // R4
  no_wrap_bottom_chk: assert property (@(posedge clk) disable iff (!por_n)
    (pos_q == '0) |=> (pos_q != POS_TOP));

  // R8
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
    busy_q |=> $stable(pos_q));

  // R6
  nv_write_window_chk: assert property (@(posedge clk) disable iff (!por_n)
    (nv_data != $past(nv_data)) |-> $past(busy_q));

  // R9
  standby_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(standby && store_busy));
endmodule

// File: tb/tapwiper_ctrl_tb.sv
module tapwiper_ctrl_tb;
  localparam int TAPS = 32;
  localparam int STC  = 16;
  localparam int NVI  = 5;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic sel_n = 1'b1;
  logic inc_n = 1'b1;
  logic dir_up = 1'b0;
  logic [TAPS-1:0] tap_sel;
  logic [4:0] position;
  logic store_busy, standby;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tapwiper_ctrl #(.TAPS(TAPS), .STORE_CYCLES(STC), .NV_INIT(NVI)) u_dut (
    .clk(clk), .por_n(por_n), .sel_n(sel_n), .inc_n(inc_n), .dir_up(dir_up),
    .tap_sel(tap_sel), .position(position), .store_busy(store_busy),
    .standby(standby)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model: inputs seen through a three-sample history
  int m_pos = NVI, m_nv = NVI, m_cnt = 0;
  bit m_busy = 0, m_sess = 0, m_live = 0;
  bit hs[3] = '{1, 1, 1};
  bit hi[3] = '{1, 1, 1};
  bit hd[3] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!por_n) begin
      m_pos = m_nv; m_busy = 0; m_cnt = 0; m_sess = 0;
      hs = '{1, 1, 1}; hi = '{1, 1, 1}; hd = '{0, 0, 0};
    end else begin
      bit busy0, sess0, sfall, srise, ifall;
      busy0 = m_busy; sess0 = m_sess;
      sfall = hs[2] && !hs[1];
      srise = !hs[2] && hs[1];
      ifall = hi[2] && !hi[1];
      if (busy0) begin
        if (m_cnt == 0) begin m_busy = 0; m_nv = m_pos; end
        else m_cnt--;
      end
      if (sess0 && !hs[1] && ifall) begin
        if (hd[1]) m_pos = (m_pos < TAPS - 1) ? m_pos + 1 : m_pos;
        else       m_pos = (m_pos > 0) ? m_pos - 1 : 0;
      end
      if (sess0 && srise) begin
        m_sess = 0;
        if (hi[1]) begin m_busy = 1; m_cnt = STC - 1; end
      end else if (!sess0 && sfall && !busy0) begin
        m_sess = 1;
      end
      hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = sel_n;
      hi[2] = hi[1]; hi[1] = hi[0]; hi[0] = inc_n;
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = dir_up;
    end
    m_live = 1;
  end

  always @(negedge clk) begin
    if (m_live && !finished) begin
      chk("R3 position vs model", position, m_pos);
      chk("R2 tap_sel vs model", tap_sel, longint'(64'd1 << m_pos));
      chk("R6 store_busy vs model", store_busy, m_busy);
      chk("R9 standby vs model", standby, (!m_sess && !m_busy));
    end
  end

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(bit up);
    dir_up = up; inc_n = 1'b0; wait_n(4);
    inc_n = 1'b1; wait_n(4);
  endtask

  task automatic pulses(bit up, int n);
    for (int i = 0; i < n; i++) pulse(up);
  endtask

  task automatic select_on();
    sel_n = 1'b0; wait_n(5);
  endtask

  task automatic power_cycle();
    por_n = 1'b0; wait_n(3);
    por_n = 1'b1; wait_n(4);
  endtask

  initial begin
    int blen;
    wait_n(3);
    por_n = 1'b1;
    wait_n(4);
    chk("R1 blank-cell recall", position, NVI);
    chk("R2 one-hot tap", tap_sel, longint'(64'd1 << NVI));
    chk("R9 standby after reset", standby, 1);

    pulses(1, 3);
    chk("R5 strobes while deselected", position, NVI);

    select_on();
    chk("R9 standby low when selected", standby, 0);
    pulses(1, 3);
    chk("R3 three up steps", position, 8);
    pulses(0, 2);
    chk("R10 direction change in session", position, 6);
    pulses(1, 30);
    chk("R4 saturate at top", position, 31);

    // store with strobe high, measure the busy window
    sel_n = 1'b1;
    blen = 0;
    for (int i = 0; i < 10 && !store_busy; i++) @(negedge clk);
    while (store_busy && blen < 100) begin blen++; @(negedge clk); end
    chk("R6 busy length", blen, STC);
    chk("R6 position kept after store", position, 31);
    power_cycle();
    chk("R6 recall stored value", position, 31);

    // activity during the store is ignored
    select_on();
    pulse(0);
    chk("R3 single down step", position, 30);
    sel_n = 1'b1;
    for (int i = 0; i < 10 && !store_busy; i++) @(negedge clk);
    sel_n = 1'b0; wait_n(5);
    pulse(0);
    chk("R8 strobe during store ignored", position, 30);
    for (int i = 0; i < 40 && store_busy; i++) @(negedge clk);
    wait_n(3);
    pulse(0);
    chk("R8 selection begun in store stays inactive", position, 30);
    sel_n = 1'b1; wait_n(6);
    chk("R9 standby after store", standby, 1);
    power_cycle();
    chk("R6 second recall", position, 30);

    // deselect with strobe low: no store
    select_on();
    pulses(0, 40);
    chk("R4 saturate at bottom", position, 0);
    inc_n = 1'b0; wait_n(4);
    sel_n = 1'b1; wait_n(4);
    chk("R7 no busy without store", store_busy, 0);
    chk("R7 position kept", position, 0);
    inc_n = 1'b1; wait_n(4);
    power_cycle();
    chk("R7 recall older value", position, 30);

    // reset in the middle of a store
    select_on();
    pulses(0, 3);
    chk("R3 down to 27", position, 27);
    sel_n = 1'b1;
    for (int i = 0; i < 10 && !store_busy; i++) @(negedge clk);
    wait_n(3);
    chk("R6 busy during store", store_busy, 1);
    power_cycle();
    chk("R11 aborted store keeps old value", position, 30);
    chk("R11 busy cleared", store_busy, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule